// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block collects five interrupt sources for a small processor core and presents the one that should be taken at the next instruction boundary. The five sources are a nonmaskable trap, three restart inputs with individual masks, and a general request whose vector the core has to fetch from the data bus. Each input has its own sensing rule. The trap is qualified by both an edge and a level. The highest restart input is caught by a rising-edge latch. The two lower restart inputs and the general request are level sensitive.

Every input first passes through a synchronizer. The core drives a strobe at each instruction boundary, and on that strobe the controller registers the winning request, its source code and its restart vector. The core signals acceptance with a one-cycle acknowledge. The acknowledge withdraws the presented request and applies that source's clear rule. Software-style strobes set and clear the global enable, write the three masks and clear the edge latch. A status word reports the pending inputs, the enable and the masks.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several qualified requests are present at a boundary, the winner is fixed by priority: trap (source code 4) beats restart-high (3), which beats restart-mid (2), which beats restart-low (1), which beats the general request (0). The registered vectors are 0x24 for the trap, 0x3C for restart-high, 0x34 for restart-mid and 0x2C for restart-low.
- R2: The general request and the three restart inputs are taken only while the global enable is set. `ei_i` sets the enable, `di_i` clears it, and reset clears it.
- R3: The trap is taken regardless of the enable and of every mask.
- R4: Mask bit 0 blocks restart-low, bit 1 blocks restart-mid and bit 2 blocks restart-high. The masks change only on `msk_we_i` or on reset, and reset sets all three.
- R5: Restart-low and restart-mid are level sensitive. A level that has dropped before the boundary produces no request.
- R6: A rising edge on restart-high sets an internal latch even while that input is masked. The latch then requests service once the input is unmasked, even if the pin has already returned low.
- R7: The restart-high latch is cleared by acknowledging a restart-high request, by `clr75_i`, or by reset.
- R8: The trap is recognized only after a rising edge and only while its input is still high. After it has been acknowledged, it is not recognized again until the input has gone low and then high.
- R9: A general-request win raises `ext_vec_o` with source code 0 and vector 0x00.
- R10: Acknowledging any maskable source clears the global enable. Acknowledging the trap leaves the enable unchanged.
- R11: The request outputs change only on a boundary strobe or an acknowledge, and are low in the cycle after an acknowledge.
- R12: `status_o` reads {restart-high latch, restart-mid level, restart-low level, enable, mask[2:0]} from bit 6 down to bit 0. The pending bits do not depend on the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_i | input | 1 | Nonmaskable trap input, asynchronous |
| rst75_i | input | 1 | Restart-high input, edge latched |
| rst65_i | input | 1 | Restart-mid input, level |
| rst55_i | input | 1 | Restart-low input, level |
| intr_i | input | 1 | General request, level |
| boundary_i | input | 1 | Instruction boundary sampling strobe |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| msk_we_i | input | 1 | Write masks |
| msk_i | input | 3 | Mask values, bit 0 low .. bit 2 high |
| clr75_i | input | 1 | Clear restart-high latch |
| ack_i | input | 1 | Core accepts presented request |
| irq_req_o | output | 1 | Request presented |
| irq_src_o | output | 3 | Winning source code |
| vec_o | output | 8 | Restart vector |
| ext_vec_o | output | 1 | Vector must be fetched from the bus |
| status_o | output | 7 | Pending, enable and mask status |

## Verification
A wrong enable or mask register shows up at the next boundary strobe, either as a request that should not be there or as a missing one, and it also appears at once in `status_o`. A restart-high latch that is stuck or that was lost is visible in status bit 6 one cycle after the faulty update. A trap qualifier that does not rearm correctly appears as a second trap presentation, or a missing one, at the boundary after the acknowledge. Every case is therefore observable within a few cycles of the faulty update.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int NSRC  = 5;
  localparam int SRC_W = 3;
  localparam int VEC_W = 8;
  localparam int MSK_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_INTR = 3'd0,
    SRC_R55  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R75  = 3'd3,
    SRC_TRAP = 3'd4
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(logic [SRC_W-1:0] s);
    case (s)
      SRC_TRAP: vec_of = 8'h24;
      SRC_R75:  vec_of = 8'h3C;
      SRC_R65:  vec_of = 8'h34;
      SRC_R55:  vec_of = 8'h2C;
      default:  vec_of = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch #(
  parameter bit QUALIFY = 1'b0  // 1: drop when level falls
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic q_o
);
  logic prev_q, lat_q, rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  // set wins so a fresh edge is never lost
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 lat_q <= 1'b0;
    else if (rise)               lat_q <= 1'b1;
    else if (clr_i)              lat_q <= 1'b0;
    else if (QUALIFY && !lvl_i)  lat_q <= 1'b0;

  assign q_o = lat_q;

  // R6
  rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> q_o);

  if (QUALIFY) begin : g_qual_chk
    // R8
    drop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lvl_i |=> !q_o);
  end
endmodule

// File: rtl/irq_arb.sv
`timescale 1ns/1ps
module irq_arb #(
  parameter int N     = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,  // higher index wins
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (req_i[i]) idx_o = IDX_W'(i);
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic             rst75_i,
  input  logic             rst65_i,
  input  logic             rst55_i,
  input  logic             intr_i,
  input  logic             boundary_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             msk_we_i,
  input  logic [MSK_W-1:0] msk_i,
  input  logic             clr75_i,
  input  logic             ack_i,
  output logic             irq_req_o,
  output logic [SRC_W-1:0] irq_src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_vec_o,
  output logic [6:0]       status_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  s;
  logic             trap_lat, r75_lat;
  logic             ie_q;
  logic [MSK_W-1:0] mask_q;
  logic [NSRC-1:0]  req_vec;
  logic             any;
  logic [IDX_W-1:0] idx;
  logic             req_q, ext_q;
  logic [SRC_W-1:0] src_q;
  logic [VEC_W-1:0] vec_q;
  logic             ack_take, ack_trap, ack_r75;

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({trap_i, rst75_i, rst65_i, rst55_i, intr_i}),
    .q_o   (s)
  );

  assign ack_take = ack_i & req_q;
  assign ack_trap = ack_take & (src_q == SRC_TRAP);
  assign ack_r75  = ack_take & (src_q == SRC_R75);

  irq_edge_latch #(.QUALIFY(1'b1)) i_trap_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (s[SRC_TRAP]),
    .clr_i (ack_trap),
    .q_o   (trap_lat)
  );

  irq_edge_latch #(.QUALIFY(1'b0)) i_r75_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (s[SRC_R75]),
    .clr_i (ack_r75 | clr75_i),
    .q_o   (r75_lat)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                ie_q <= 1'b0;
    else if (ack_take && src_q != SRC_TRAP)     ie_q <= 1'b0;
    else if (di_i)                              ie_q <= 1'b0;
    else if (ei_i)                              ie_q <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       mask_q <= '1;
    else if (msk_we_i) mask_q <= msk_i;

  assign req_vec[SRC_TRAP] = trap_lat & s[SRC_TRAP];
  assign req_vec[SRC_R75]  = r75_lat  & ~mask_q[2] & ie_q;
  assign req_vec[SRC_R65]  = s[SRC_R65] & ~mask_q[1] & ie_q;
  assign req_vec[SRC_R55]  = s[SRC_R55] & ~mask_q[0] & ie_q;
  assign req_vec[SRC_INTR] = s[SRC_INTR] & ie_q;

  irq_arb #(.N(NSRC)) i_arb (
    .req_i(req_vec),
    .any_o(any),
    .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      req_q <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
      ext_q <= 1'b0;
    end else if (ack_i) begin
      req_q <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
      ext_q <= 1'b0;
    end else if (boundary_i) begin
      req_q <= any;
      src_q <= any ? SRC_W'(idx) : '0;
      vec_q <= any ? vec_of(SRC_W'(idx)) : '0;
      ext_q <= any && (SRC_W'(idx) == SRC_INTR);
    end

  assign irq_req_o = req_q;
  assign irq_src_o = src_q;
  assign vec_o     = vec_q;
  assign ext_vec_o = ext_q;
  assign status_o  = {r75_lat, s[SRC_R65], s[SRC_R55], ie_q, mask_q};

  // R11
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_req_o);

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boundary_i && !ack_i) |=> $stable({irq_req_o, irq_src_o, vec_o, ext_vec_o}));

  // R10
  ie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_req_o && irq_src_o != SRC_TRAP) |=> !status_o[3]);

  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msk_we_i |=> $stable(status_o[2:0]));

  // R3
  trap_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !ack_i && trap_lat && s[SRC_TRAP]) |=>
      (irq_req_o && irq_src_o == SRC_TRAP && vec_o == 8'h24));

  // R9
  ext_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_vec_o |-> (irq_req_o && irq_src_o == SRC_INTR && vec_o == 8'h00));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] ins = '0;  // {trap, r75, r65, r55, intr}
  logic       boundary = 0, ei = 0, di = 0, msk_we = 0, clr75 = 0, ack = 0;
  logic [2:0] msk = '0;
  logic       req, ext;
  logic [2:0] src;
  logic [7:0] vec;
  logic [6:0] status;
  int         errors = 0, checks = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .trap_i(ins[4]), .rst75_i(ins[3]), .rst65_i(ins[2]), .rst55_i(ins[1]), .intr_i(ins[0]),
    .boundary_i(boundary), .ei_i(ei), .di_i(di), .msk_we_i(msk_we), .msk_i(msk),
    .clr75_i(clr75), .ack_i(ack),
    .irq_req_o(req), .irq_src_o(src), .vec_o(vec), .ext_vec_o(ext), .status_o(status)
  );

  // {ins[4:0], ie, mask[2:0], exp_req, exp_src[2:0], exp_vec[7:0]}
  localparam int NV = 11;
  localparam logic [20:0] VTAB [NV] = '{
    {5'b11111, 1'b1, 3'b000, 1'b1, 3'd4, 8'h24},  // R1 R3
    {5'b01111, 1'b1, 3'b000, 1'b1, 3'd3, 8'h3C},  // R1
    {5'b00111, 1'b1, 3'b000, 1'b1, 3'd2, 8'h34},  // R1
    {5'b00011, 1'b1, 3'b000, 1'b1, 3'd1, 8'h2C},  // R1
    {5'b00001, 1'b1, 3'b000, 1'b1, 3'd0, 8'h00},  // R9
    {5'b01111, 1'b0, 3'b000, 1'b0, 3'd0, 8'h00},  // R2
    {5'b10000, 1'b0, 3'b111, 1'b1, 3'd4, 8'h24},  // R3
    {5'b01110, 1'b1, 3'b100, 1'b1, 3'd2, 8'h34},  // R4
    {5'b00111, 1'b1, 3'b011, 1'b1, 3'd0, 8'h00},  // R4
    {5'b01000, 1'b1, 3'b011, 1'b1, 3'd3, 8'h3C},  // R4
    {5'b00010, 1'b1, 3'b001, 1'b0, 3'd0, 8'h00}   // R4
  };

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic set_mask(logic [2:0] m);
    msk = m;
    strobe(msk_we);
  endtask

  task automatic chk_out(string rq, logic r, logic [2:0] s, logic [7:0] v);
    chk(rq, {20'd0, r, ext, s, vec}, {20'd0, r, (r && s == 3'd0), s, v});
    chk(rq, {31'd0, req}, {31'd0, r});
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    settle(2);
    rst_ni = 1'b1;
    settle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(2);
    rst_ni = 1'b1;
    settle(1);
    // R4 R12 reset state
    chk("R12 reset status", {25'd0, status}, 32'h07);
    chk("R11 reset req", {31'd0, req}, 0);

    for (int e = 0; e < NV; e++) begin
      ins = '0;
      settle(5);
      strobe(clr75);
      set_mask(VTAB[e][14:12]);
      if (VTAB[e][15]) strobe(ei); else strobe(di);
      ins = VTAB[e][20:16];
      settle(5);
      strobe(boundary);
      chk_out("R1 table", VTAB[e][11], VTAB[e][10:8], VTAB[e][7:0]);
    end
    ins = '0;
    settle(5);

    // R5 level drops before boundary
    set_mask(3'b000);
    strobe(ei);
    ins = 5'b00010;
    settle(5);
    ins = '0;
    settle(5);
    strobe(boundary);
    chk_out("R5 dropped level", 0, 0, 0);

    // R11 hold between boundaries, drop on ack
    ins = 5'b00100;
    settle(5);
    strobe(boundary);
    chk_out("R11 presented", 1, 3'd2, 8'h34);
    ins = '0;
    settle(5);
    chk_out("R11 held", 1, 3'd2, 8'h34);
    strobe(ack);
    chk_out("R11 after ack", 0, 0, 0);
    chk("R10 ie cleared", {31'd0, status[3]}, 0);

    // R6 masked edge latched, serviced after unmask
    set_mask(3'b111);
    strobe(ei);
    ins = 5'b01000;
    settle(4);
    ins = '0;
    settle(5);
    chk("R6 latch pending while masked", {31'd0, status[6]}, 1);
    strobe(boundary);
    chk_out("R6 masked no req", 0, 0, 0);
    set_mask(3'b000);
    strobe(boundary);
    chk_out("R6 unmasked req", 1, 3'd3, 8'h3C);
    strobe(ack);
    chk("R7 ack clears latch", {31'd0, status[6]}, 0);
    chk("R10 ie cleared r75", {31'd0, status[3]}, 0);

    // R7 clear strobe
    ins = 5'b01000;
    settle(4);
    ins = '0;
    settle(5);
    chk("R7 latch set", {31'd0, status[6]}, 1);
    strobe(clr75);
    chk("R7 clr strobe", {31'd0, status[6]}, 0);

    // R8 trap rearm rules
    strobe(ei);
    ins = 5'b10000;
    settle(5);
    strobe(boundary);
    chk_out("R8 trap taken", 1, 3'd4, 8'h24);
    strobe(ack);
    chk("R10 trap keeps ie", {31'd0, status[3]}, 1);
    settle(3);
    strobe(boundary);
    chk_out("R8 no retrigger while high", 0, 0, 0);
    ins = '0;
    settle(5);
    ins = 5'b10000;
    settle(5);
    strobe(boundary);
    chk_out("R8 retrigger after low-high", 1, 3'd4, 8'h24);
    strobe(ack);
    ins = '0;
    settle(5);
    ins = 5'b10000;
    settle(5);
    ins = '0;
    settle(5);
    strobe(boundary);
    chk_out("R8 trap dropped before boundary", 0, 0, 0);

    // R2 disable then enable; lower priority after re-enable
    strobe(di);
    ins = 5'b00010;
    settle(5);
    strobe(boundary);
    chk_out("R2 disabled", 0, 0, 0);
    strobe(ei);
    strobe(boundary);
    chk_out("R2 enabled", 1, 3'd1, 8'h2C);
    strobe(ack);
    ins = '0;
    settle(5);

    // R7 reset clears latch, R4 reset sets masks
    ins = 5'b01000;
    settle(4);
    ins = '0;
    settle(5);
    chk("R7 latch before reset", {31'd0, status[6]}, 1);
    do_reset();
    chk("R7 reset status", {25'd0, status}, 32'h07);

    // R12 pending bits ignore masks
    ins = 5'b00110;
    settle(5);
    chk("R12 pending with masks", {25'd0, status}, 32'h37);
    ins = '0;
    settle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule